// File: doc/BRIEF.md
# Interlocked Serial Port Control Register

This block holds the 16-bit control word of a serial audio port. Software reaches it over a minimal register bus: a select line marks an address match, a write strobe qualifies the cycle, and the write data is captured on the clock edge. The read data always shows the current register contents. Reserved positions read as zero, and so does any enable that its dependencies currently lock.

One master enable sits over every other enable. The three input-port enables, the second-output enable and the serial-clock enable are accepted only while their conditions hold. The second output also requires an external alternate-output busy input to be low. The serial clock also requires an external power-down input to be low. When a condition is lost, the dependent enable clears itself on the next clock edge. A write that sets the master enable also has its dependent bits accepted in that same write.

The block also keeps a five-bit pin-configuration vector for the general-purpose pins that the port borrows. A bit is 1 when its pin stays general-purpose and 0 when the port has claimed it. A 2-bit format field chooses one framing for all serial ports.

Top module: `serial_port_ctl`

## Requirements
- R1: After reset the read data is 0x0000, every enable output and the format output are 0, and pin_cfg is 5'b11111.
- R2: Bit 15 is the master enable and can be written freely. Bit 14 and bits 10 down to 4 always read 0.
- R3: The input-port enables (bit 11 = port 0, bit 12 = port 1, bit 13 = port 2) are stored only when the master enable is 1 after the write. A write that sets bit 15 together with them is accepted.
- R4: When the master enable goes to 0, all input-port enables clear. They stay 0 after the master enable is set again, until they are written again.
- R5: The second-output enable (bit 3) is stored only when the master enable is 1 and alt_out_busy is 0. Otherwise it reads 0.
- R6: The serial-clock enable (bit 2) is stored only when the master enable is 1 and pwr_down is 0. Otherwise it reads 0.
- R7: If alt_out_busy or pwr_down rises while its dependent enable is set, that enable is 0 after the next clock edge. It stays 0 when the input falls again.
- R8: pin_cfg[1:0] are both the inverse of the master enable. pin_cfg[2+k] is the inverse of input-port enable k.
- R9: The format field in bits 1:0 stores any value whatever the master enable is, and drives fmt_sel: 00 I2S, 01 left-justified, 10 right-justified 20-bit, 11 right-justified 16-bit.
- R10: A write strobe without reg_sel leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Address match for this register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, locked enables masked to 0 |
| alt_out_busy | input | 1 | External alternate-output enable; locks the second output |
| pwr_down | input | 1 | External power-down; locks the serial clock |
| master_en | output | 1 | Master serial output enable |
| in_en | output | 3 | Input-port enables |
| out2_en | output | 1 | Second serial output enable |
| sclk_en | output | 1 | Serial clock output enable |
| fmt_sel | output | 2 | Serial data format |
| pin_cfg | output | 5 | Pin-configuration bits, 1 = pin left general-purpose |

## Verification
The bench writes all-ones and mixed patterns with the master enable both clear and set. This shows the difference between dependent bits that are refused and bits accepted in the same write. Writes are also made while each external lock input is high, and a lock input is raised after its enable is already set. These cases separate write-time refusal from automatic clearing, and check that the cleared enable does not return when the lock input falls again. Single-bit input-port patterns confirm which pin-configuration bit each port owns. A strobe without select confirms that the register ignores it.

// File: rtl/spc_pkg.sv
package spc_pkg;
    localparam int REG_W    = 16;
    localparam int N_IN     = 3;
    localparam int N_MPIN   = 2;
    localparam int N_PIN    = N_MPIN + N_IN;
    localparam int FMT_W    = 2;
    localparam int POS_MSTR = 15;
    localparam int POS_IN   = 11;
    localparam int POS_OUT2 = 3;
    localparam int POS_SCLK = 2;
    localparam int POS_FMT  = 0;

    typedef struct packed {
        logic              master;
        logic [N_IN-1:0]   in_en;
        logic              out2;
        logic              sclk;
        logic [FMT_W-1:0]  fmt;
        logic [N_PIN-1:0]  pin;
    } spc_state_t;
endpackage

// File: rtl/spc_gate.sv
module spc_gate #(
    parameter int W = 1
) (
    input  logic         allow,
    input  logic         take,
    input  logic [W-1:0] new_val,
    input  logic [W-1:0] cur_val,
    output logic [W-1:0] nxt_val
);
    always_comb begin
        if (!allow)    nxt_val = '0;
        else if (take) nxt_val = new_val;
        else           nxt_val = cur_val;
    end
endmodule

// File: rtl/spc_pinmap.sv
module spc_pinmap #(
    parameter int N_M = 2,
    parameter int N_I = 3
) (
    input  logic               master,
    input  logic [N_I-1:0]     in_en,
    output logic [N_M+N_I-1:0] pin
);
    for (genvar m = 0; m < N_M; m++) begin : g_mpin
        assign pin[m] = ~master;
    end
    for (genvar k = 0; k < N_I; k++) begin : g_ipin
        assign pin[N_M+k] = ~in_en[k];
    end
endmodule

// File: rtl/serial_port_ctl.sv
module serial_port_ctl
    import spc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic             alt_out_busy,
    input  logic             pwr_down,
    output logic             master_en,
    output logic [2:0]       in_en,
    output logic             out2_en,
    output logic             sclk_en,
    output logic [1:0]       fmt_sel,
    output logic [4:0]       pin_cfg
);
    spc_state_t st_q, st_d;
    logic       wr_hit;
    logic       mstr_d;
    logic [N_IN-1:0] in_d;
    logic       out2_d, sclk_d;
    logic [N_PIN-1:0] pin_d;

    assign wr_hit = reg_sel & reg_wr;
    assign mstr_d = wr_hit ? reg_wdata[POS_MSTR] : st_q.master;

    spc_gate #(.W(N_IN)) u_gate_in (
        .allow   (mstr_d),
        .take    (wr_hit),
        .new_val (reg_wdata[POS_IN +: N_IN]),
        .cur_val (st_q.in_en),
        .nxt_val (in_d)
    );

    spc_gate #(.W(1)) u_gate_out2 (
        .allow   (mstr_d & ~alt_out_busy),
        .take    (wr_hit),
        .new_val (reg_wdata[POS_OUT2]),
        .cur_val (st_q.out2),
        .nxt_val (out2_d)
    );

    spc_gate #(.W(1)) u_gate_sclk (
        .allow   (mstr_d & ~pwr_down),
        .take    (wr_hit),
        .new_val (reg_wdata[POS_SCLK]),
        .cur_val (st_q.sclk),
        .nxt_val (sclk_d)
    );

    spc_pinmap #(.N_M(N_MPIN), .N_I(N_IN)) u_pinmap (
        .master (mstr_d),
        .in_en  (in_d),
        .pin    (pin_d)
    );

    always_comb begin
        st_d        = st_q;
        st_d.master = mstr_d;
        st_d.in_en  = in_d;
        st_d.out2   = out2_d;
        st_d.sclk   = sclk_d;
        st_d.pin    = pin_d;
        if (wr_hit) st_d.fmt = reg_wdata[POS_FMT +: FMT_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.pin    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign master_en = st_q.master;
    assign in_en     = st_q.in_en;
    assign out2_en   = st_q.out2 & ~alt_out_busy;
    assign sclk_en   = st_q.sclk & ~pwr_down;
    assign fmt_sel   = st_q.fmt;
    assign pin_cfg   = st_q.pin;

    always_comb begin
        reg_rdata                        = '0;
        reg_rdata[POS_MSTR]              = master_en;
        reg_rdata[POS_IN +: N_IN]        = in_en;
        reg_rdata[POS_OUT2]              = out2_en;
        reg_rdata[POS_SCLK]              = sclk_en;
        reg_rdata[POS_FMT +: FMT_W]      = fmt_sel;
    end
endmodule

// File: rtl/serial_port_ctl_chk.sv
module serial_port_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_sel,
    input logic        reg_wr,
    input logic [15:0] reg_rdata,
    input logic        alt_out_busy,
    input logic        pwr_down,
    input logic        master_en,
    input logic [2:0]  in_en,
    input logic        out2_en,
    input logic        sclk_en,
    input logic [1:0]  fmt_sel,
    input logic [4:0]  pin_cfg
);
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[14] == 1'b0) && (reg_rdata[10:4] == 7'd0)); // R2
    AST_IN_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_en != 3'd0) |-> master_en); // R3
    AST_MASTER_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(master_en) |-> (in_en == 3'd0)); // R4
    AST_OUT2_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(alt_out_busy) |-> !out2_en); // R5
    AST_SCLK_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_down) |-> !sclk_en); // R6
    AST_PIN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        pin_cfg == {~in_en, ~master_en, ~master_en}); // R8
    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && reg_wr) |=> $stable(fmt_sel)); // R10
endmodule

bind serial_port_ctl serial_port_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_sel      (reg_sel),
    .reg_wr       (reg_wr),
    .reg_rdata    (reg_rdata),
    .alt_out_busy (alt_out_busy),
    .pwr_down     (pwr_down),
    .master_en    (master_en),
    .in_en        (in_en),
    .out2_en      (out2_en),
    .sclk_en      (sclk_en),
    .fmt_sel      (fmt_sel),
    .pin_cfg      (pin_cfg)
);

// File: tb/serial_port_ctl_bench.sv
module serial_port_ctl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        alt_out_busy = 1'b0, pwr_down = 1'b0;
    logic        master_en, out2_en, sclk_en;
    logic [2:0]  in_en;
    logic [1:0]  fmt_sel;
    logic [4:0]  pin_cfg;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        logic [15:0] rd;
        logic [4:0]  pin;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_port_ctl u_serial_port_ctl (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .alt_out_busy(alt_out_busy), .pwr_down(pwr_down),
        .master_en(master_en), .in_en(in_en), .out2_en(out2_en),
        .sclk_en(sclk_en), .fmt_sel(fmt_sel), .pin_cfg(pin_cfg)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: compare after each edge for which an item was queued
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(reg_rdata == e.rd, e.tag, "rdata", reg_rdata, e.rd);
            check(pin_cfg == e.pin, e.tag, "pin_cfg", {11'd0, pin_cfg}, {11'd0, e.pin});
            check({master_en, in_en, out2_en, sclk_en, fmt_sel} ==
                  {e.rd[15], e.rd[13:11], e.rd[3:0]}, e.tag, "enable lines",
                  {8'd0, master_en, in_en, out2_en, sclk_en, fmt_sel},
                  {8'd0, e.rd[15], e.rd[13:11], e.rd[3:0]});
        end
    end

    // driver: set inputs at negedge, queue result expected after next posedge
    task automatic step(input bit sel, input bit wr, input logic [15:0] wd,
                        input bit busy, input bit pd,
                        input logic [15:0] exp_rd, input logic [4:0] exp_pin,
                        input string tag);
        exp_t e;
        @(negedge clk);
        reg_sel = sel; reg_wr = wr; reg_wdata = wd;
        alt_out_busy = busy; pwr_down = pd;
        e.rd = exp_rd; e.pin = exp_pin; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (2000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(reg_rdata == 16'h0000, "R1", "reset rdata", reg_rdata, 16'h0000);
        check(pin_cfg == 5'h1F, "R1", "reset pin_cfg", {11'd0, pin_cfg}, 16'h001F);
        rst_n = 1'b1;
        step(0, 0, 16'h0000, 0, 0, 16'h0000, 5'h1F, "R1 idle");
        step(1, 1, 16'h380F, 0, 0, 16'h0003, 5'h1F, "R3/R9 master off");
        step(0, 1, 16'hFFFF, 0, 0, 16'h0003, 5'h1F, "R10 no select");
        step(1, 1, 16'hFFFF, 0, 0, 16'hB80F, 5'h00, "R2/R3 same write");
        step(1, 1, 16'h9000, 0, 0, 16'h9000, 5'h14, "R8 port1 pin");
        step(1, 1, 16'h800D, 1, 0, 16'h8005, 5'h1C, "R5 busy refuses");
        step(0, 0, 16'h0000, 0, 1, 16'h8001, 5'h1C, "R7 pd clears sclk");
        step(0, 0, 16'h0000, 0, 0, 16'h8001, 5'h1C, "R7 stays clear");
        step(1, 1, 16'h880C, 0, 1, 16'h8808, 5'h18, "R6 pd refuses");
        step(1, 1, 16'h880E, 0, 0, 16'h880E, 5'h18, "R6/R9 accept");
        step(0, 0, 16'h0000, 1, 0, 16'h8806, 5'h18, "R7 busy clears out2");
        step(1, 1, 16'h3806, 1, 0, 16'h0002, 5'h1F, "R4 master drop");
        step(1, 1, 16'h8000, 1, 0, 16'h8000, 5'h1C, "R4 no return");
        step(1, 1, 16'h0000, 0, 0, 16'h0000, 5'h1F, "R8 release pins");
        @(negedge clk);
        @(negedge clk);
        check(sb_q.size() == 0, "scoreboard", "drained", 16'(sb_q.size()), 16'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule